// File: doc/BRIEF.md
# Total-Power Automatic Gain Control Loop

This block regulates the level of the intermediate-frequency signal that feeds a digital demodulator. It works on the digitised in-phase and quadrature samples ahead of carrier recovery. It measures their power as I²+Q², which needs neither carrier lock nor symbol-timing lock. It averages that power over a programmable block of 2^N valid samples and subtracts the average from a programmable reference. The resulting error passes through a proportional-plus-integral (second-order) loop filter, and the filter produces an unsigned gain word.

The upper bits of the gain word drive a first-order delta-sigma modulator. The modulator produces one control bit per clock, and the density of ones in that bit follows the gain word. An external RC lowpass turns the bit stream into the control voltage of a variable-gain amplifier. A polarity input inverts the bit stream for amplifiers whose gain falls as the control voltage rises. The gain word is also brought out so it can be observed.

A four-state controller sequences the work. ST_IDLE holds everything while `enable` is low. Rising `enable` takes ST_IDLE to ST_COLLECT. ST_COLLECT accumulates sample power. It moves to ST_ERROR when the last sample of a block is accepted, and it returns to ST_IDLE when `enable` falls. ST_ERROR forms the averaged error and always moves to ST_FILTER. ST_FILTER updates the integrator and the gain word. It then moves to ST_COLLECT if `enable` is high, or to ST_IDLE if it is low.

Top module: `tp_agc`

## Requirements
- R1: While reset is asserted, `gain_word` equals GAIN_INIT (default 32768) and `agc_bit` is 0.
- R2: Sample power is smp_i²+smp_q², where both samples are two's-complement numbers. A block is 2^N accepted samples, with N = `cfg_avg_log2` limited to LOGN_MAX (default 8). The error is `cfg_ref` minus (block power sum shifted right by N).
- R3: Each block updates the loop filter once. The integrator becomes clip(integrator + (err >>> `cfg_ki_shift`)). The gain word then becomes clip(integrator + (err >>> `cfg_kp_shift`)). The shifts are arithmetic, and clip limits a value to the range 0 to 2^GAIN_W−1. The gain word changes only on the clock edge that ends ST_FILTER.
- R4: The integrator itself is clipped to the range 0 to 2^GAIN_W−1. After a long period of saturation, an error of the opposite sign therefore moves the gain away from the rail on the very next block.
- R5: The gain word never leaves the range 0 to 2^GAIN_W−1. A sum outside that range gives exactly 0 or exactly 2^GAIN_W−1.
- R6: Cycles with `smp_valid` low do not count toward the block and do not add to the power sum, whatever sample values are present.
- R7: Samples presented while the controller is in ST_ERROR or ST_FILTER are discarded. They are not carried into the next block.
- R8: Lowering `enable` discards a partly collected block, and the gain word is held for as long as `enable` stays low.
- R9: `agc_bit` comes from a first-order delta-sigma modulator on the top DSM_W bits of the gain word (default: bits 15:8). Over any 2^DSM_W consecutive clocks with a constant gain word, the number of ones equals the value of those top bits.
- R10: When `cfg_invert` is 1, `agc_bit` is inverted. Over 2^DSM_W clocks the count of ones is then 2^DSM_W minus the value of the top bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the measurement loop when high |
| smp_valid | input | 1 | Marks a valid I/Q sample |
| smp_i | input | 6 | In-phase sample, two's complement |
| smp_q | input | 6 | Quadrature sample, two's complement |
| cfg_ref | input | 13 | Target mean power |
| cfg_avg_log2 | input | 4 | Block length exponent N |
| cfg_kp_shift | input | 4 | Proportional-path right shift |
| cfg_ki_shift | input | 4 | Integral-path right shift |
| cfg_invert | input | 1 | Inverts the control bit |
| agc_bit | output | 1 | Density-modulated gain control bit |
| gain_word | output | 16 | Filtered gain word |

## Verification
Two events can fall in the same cycle: the end of one block and the arrival of the first samples of the next. A directed test keeps `smp_valid` high straight across the block boundary. It places full-scale samples in the two cycles spent in ST_ERROR and ST_FILTER and follows them with a full second block. The gain word after that second block is compared with a model that leaves those two samples out. A second test lowers `enable` in the middle of a block, checks that the gain is held, and checks that the next complete block is computed without the discarded partial sum.

// File: rtl/tp_agc_pkg.sv
package tp_agc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_ERROR   = 2'd2,
        ST_FILTER  = 2'd3
    } agc_state_e;

endpackage

// File: rtl/tp_agc_power.sv
module tp_agc_power #(
    parameter int SAMP_W = 6,
    parameter int PWR_W  = 2 * SAMP_W + 1
) (
    input  logic signed [SAMP_W-1:0] s_i,
    input  logic signed [SAMP_W-1:0] s_q,
    output logic        [PWR_W-1:0]  pwr
);

    localparam int SQ_W = 2 * SAMP_W;

    logic signed [SQ_W-1:0] lane [2];
    logic signed [SAMP_W-1:0] src [2];

    assign src[0] = s_i;
    assign src[1] = s_q;

    // one squarer per lane
    for (genvar g = 0; g < 2; g++) begin : g_sq
        always_comb begin
            lane[g] = src[g] * src[g];
        end
    end

    always_comb begin
        pwr = PWR_W'($unsigned(lane[0])) + PWR_W'($unsigned(lane[1]));
    end

endmodule

// File: rtl/tp_agc_ctrl.sv
module tp_agc_ctrl
    import tp_agc_pkg::*;
#(
    parameter int PWR_W    = 13,
    parameter int LOGN_MAX = 8,
    parameter int NSEL_W   = 4,
    parameter int CNT_W    = LOGN_MAX + 1,
    parameter int ERR_W    = PWR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    smp_valid,
    input  logic [PWR_W-1:0]        pwr,
    input  logic [PWR_W-1:0]        cfg_ref,
    input  logic [NSEL_W-1:0]       cfg_avg_log2,
    output agc_state_e              state,
    output logic [CNT_W-1:0]        blk_cnt,
    output logic signed [ERR_W-1:0] err_q,
    output logic                    upd
);

    localparam int ACC_W = PWR_W + LOGN_MAX;

    agc_state_e         state_q, state_d;
    logic [ACC_W-1:0]   acc_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [NSEL_W-1:0]  n_eff;
    logic [CNT_W-1:0]   last_cnt;
    logic [PWR_W-1:0]   mean_p;

    always_comb begin
        n_eff    = (cfg_avg_log2 > NSEL_W'(LOGN_MAX)) ? NSEL_W'(LOGN_MAX) : cfg_avg_log2;
        last_cnt = (CNT_W'(1) << n_eff) - CNT_W'(1);
        mean_p   = PWR_W'(acc_q >> n_eff);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (enable) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (!enable)
                    state_d = ST_IDLE;
                else if (smp_valid && (cnt_q == last_cnt))
                    state_d = ST_ERROR;
            end
            ST_ERROR:   state_d = ST_FILTER;
            ST_FILTER:  state_d = enable ? ST_COLLECT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // per-state datapath actions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            err_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    acc_q <= '0;
                    cnt_q <= '0;
                end
                ST_COLLECT: begin
                    if (!enable) begin
                        acc_q <= '0;
                        cnt_q <= '0;
                    end else if (smp_valid) begin
                        acc_q <= acc_q + ACC_W'(pwr);
                        cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + CNT_W'(1);
                    end
                end
                ST_ERROR: begin
                    err_q <= $signed({1'b0, cfg_ref}) - $signed({1'b0, mean_p});
                    acc_q <= '0;
                    cnt_q <= '0;
                end
                ST_FILTER: begin
                    cnt_q <= '0;
                end
                default: begin
                    acc_q <= '0;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign state   = state_q;
    assign blk_cnt = cnt_q;
    assign upd     = (state_q == ST_FILTER);

endmodule

// File: rtl/tp_agc_filter.sv
module tp_agc_filter #(
    parameter int GAIN_W    = 16,
    parameter int ERR_W     = 14,
    parameter int SH_W      = 4,
    parameter int GAIN_INIT = 1 << (GAIN_W - 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [ERR_W-1:0] err,
    input  logic [SH_W-1:0]         kp_sh,
    input  logic [SH_W-1:0]         ki_sh,
    output logic [GAIN_W-1:0]       gain_word
);

    localparam int INT_W = ((GAIN_W > ERR_W) ? GAIN_W : ERR_W) + 2;
    localparam logic signed [INT_W-1:0] TOP = {{(INT_W-GAIN_W){1'b0}}, {GAIN_W{1'b1}}};

    logic signed [INT_W-1:0] integ_q, err_x, prop, step, integ_sum, integ_d, gain_sum;
    logic        [GAIN_W-1:0] gain_q, gain_d;

    function automatic logic signed [INT_W-1:0] clip(input logic signed [INT_W-1:0] v);
        if (v < 0)        return '0;
        else if (v > TOP) return TOP;
        else              return v;
    endfunction

    always_comb begin
        err_x     = {{(INT_W-ERR_W){err[ERR_W-1]}}, err};
        prop      = err_x >>> kp_sh;
        step      = err_x >>> ki_sh;
        integ_sum = integ_q + step;
        integ_d   = clip(integ_sum);
        gain_sum  = integ_d + prop;
        if (gain_sum < 0)        gain_d = '0;
        else if (gain_sum > TOP) gain_d = '1;
        else                     gain_d = gain_sum[GAIN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            integ_q <= INT_W'(GAIN_INIT);
            gain_q  <= GAIN_W'(GAIN_INIT);
        end else if (upd) begin
            integ_q <= integ_d;
            gain_q  <= gain_d;
        end
    end

    assign gain_word = gain_q;

endmodule

// File: rtl/tp_agc_dsm.sv
module tp_agc_dsm #(
    parameter int DSM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DSM_W-1:0] level,
    input  logic             invert,
    output logic             bit_out
);

    logic [DSM_W-1:0] acc_q;
    logic [DSM_W:0]   sum;
    logic             bit_q;

    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, level};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else begin
            acc_q <= sum[DSM_W-1:0];
            bit_q <= sum[DSM_W] ^ invert;
        end
    end

    assign bit_out = bit_q;

endmodule

// File: rtl/tp_agc.sv
module tp_agc
    import tp_agc_pkg::*;
#(
    parameter int SAMP_W    = 6,
    parameter int GAIN_W    = 16,
    parameter int LOGN_MAX  = 8,
    parameter int SH_W      = 4,
    parameter int DSM_W     = 8,
    parameter int GAIN_INIT = 1 << (GAIN_W - 1),
    localparam int PWR_W    = 2 * SAMP_W + 1,
    localparam int NSEL_W   = $clog2(LOGN_MAX + 1),
    localparam int CNT_W    = LOGN_MAX + 1,
    localparam int ERR_W    = PWR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              smp_valid,
    input  logic [SAMP_W-1:0] smp_i,
    input  logic [SAMP_W-1:0] smp_q,
    input  logic [PWR_W-1:0]  cfg_ref,
    input  logic [NSEL_W-1:0] cfg_avg_log2,
    input  logic [SH_W-1:0]   cfg_kp_shift,
    input  logic [SH_W-1:0]   cfg_ki_shift,
    input  logic              cfg_invert,
    output logic              agc_bit,
    output logic [GAIN_W-1:0] gain_word
);

    logic [PWR_W-1:0]        pwr;
    agc_state_e              state;
    logic [CNT_W-1:0]        blk_cnt;
    logic signed [ERR_W-1:0] err;
    logic                    upd;

    tp_agc_power #(.SAMP_W(SAMP_W), .PWR_W(PWR_W)) u_power (
        .s_i (smp_i),
        .s_q (smp_q),
        .pwr (pwr)
    );

    tp_agc_ctrl #(
        .PWR_W(PWR_W), .LOGN_MAX(LOGN_MAX), .NSEL_W(NSEL_W),
        .CNT_W(CNT_W), .ERR_W(ERR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .smp_valid    (smp_valid),
        .pwr          (pwr),
        .cfg_ref      (cfg_ref),
        .cfg_avg_log2 (cfg_avg_log2),
        .state        (state),
        .blk_cnt      (blk_cnt),
        .err_q        (err),
        .upd          (upd)
    );

    tp_agc_filter #(
        .GAIN_W(GAIN_W), .ERR_W(ERR_W), .SH_W(SH_W), .GAIN_INIT(GAIN_INIT)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .err       (err),
        .kp_sh     (cfg_kp_shift),
        .ki_sh     (cfg_ki_shift),
        .gain_word (gain_word)
    );

    tp_agc_dsm #(.DSM_W(DSM_W)) u_dsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (gain_word[GAIN_W-1 -: DSM_W]),
        .invert  (cfg_invert),
        .bit_out (agc_bit)
    );

endmodule

// File: rtl/tp_agc_checker.sv
module tp_agc_checker
    import tp_agc_pkg::*;
#(
    parameter int GAIN_W    = 16,
    parameter int LOGN_MAX  = 8,
    parameter int NSEL_W    = 4,
    parameter int CNT_W     = 9,
    parameter int GAIN_INIT = 32768
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              smp_valid,
    input logic [NSEL_W-1:0] cfg_avg_log2,
    input agc_state_e        state,
    input logic [CNT_W-1:0]  blk_cnt,
    input logic [GAIN_W-1:0] gain_word
);

    logic [NSEL_W-1:0] n_chk;
    logic [CNT_W-1:0]  end_cnt;

    always_comb begin
        n_chk   = (cfg_avg_log2 > NSEL_W'(LOGN_MAX)) ? NSEL_W'(LOGN_MAX) : cfg_avg_log2;
        end_cnt = (CNT_W'(1) << n_chk) - CNT_W'(1);
    end

    a_r1_reset_gain: assert property (@(posedge clk)
        !rst_n |=> (gain_word == GAIN_W'(GAIN_INIT)));

    a_r2_block_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && enable && smp_valid && blk_cnt == end_cnt) |=> (state == ST_ERROR));

    a_r3_gain_after_filter: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_word) |-> ($past(state) == ST_FILTER));

    a_r6_invalid_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && enable && !smp_valid) |=> $stable(blk_cnt));

    a_r7_update_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILTER) |=> (blk_cnt == '0));

    a_r8_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && state != ST_FILTER) |=> $stable(gain_word));

endmodule

bind tp_agc tp_agc_checker #(
    .GAIN_W(GAIN_W), .LOGN_MAX(LOGN_MAX), .NSEL_W(NSEL_W),
    .CNT_W(CNT_W), .GAIN_INIT(GAIN_INIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .smp_valid    (smp_valid),
    .cfg_avg_log2 (cfg_avg_log2),
    .state        (state),
    .blk_cnt      (blk_cnt),
    .gain_word    (gain_word)
);

// File: tb/tp_agc_bench.sv
module tp_agc_bench;

    localparam int GMAX = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        smp_valid = 1'b0;
    logic [5:0]  smp_i = '0;
    logic [5:0]  smp_q = '0;
    logic [12:0] cfg_ref = '0;
    logic [3:0]  cfg_avg_log2 = '0;
    logic [3:0]  cfg_kp_shift = '0;
    logic [3:0]  cfg_ki_shift = '0;
    logic        cfg_invert = 1'b0;
    logic        agc_bit;
    logic [15:0] gain_word;

    always #10 clk = ~clk;

    tp_agc u_tp_agc (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
        .smp_i(smp_i), .smp_q(smp_q), .cfg_ref(cfg_ref),
        .cfg_avg_log2(cfg_avg_log2), .cfg_kp_shift(cfg_kp_shift),
        .cfg_ki_shift(cfg_ki_shift), .cfg_invert(cfg_invert),
        .agc_bit(agc_bit), .gain_word(gain_word)
    );

    typedef struct packed {
        int i; int q; int n; int rf; int kp; int ki; int gap;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{ 10,  -5, 2,  200, 2, 4, 0},
        '{-20,   7, 3,  100, 3, 2, 1},
        '{  0,   0, 0,  500, 1, 1, 0},
        '{ 29, -31, 4, 1500, 0, 3, 2},
        '{  3,   4, 1,   25, 5, 0, 0},
        '{-31, -31, 2,    0, 4, 6, 1}
    };

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int m_integ = 32768;
    int m_gain  = 32768;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clipg(input int v);
        if (v < 0) return 0;
        if (v > GMAX) return GMAX;
        return v;
    endfunction

    task automatic model(input int sum, input int n, input int rf, input int kp, input int ki);
        int err;
        err     = rf - (sum >> n);
        m_integ = clipg(m_integ + (err >>> ki));
        m_gain  = clipg(m_integ + (err >>> kp));
    endtask

    task automatic cyc(input bit v, input int i, input int q);
        @(negedge clk);
        smp_valid = v;
        smp_i     = 6'(i);
        smp_q     = 6'(q);
    endtask

    task automatic setcfg(input int n, input int rf, input int kp, input int ki);
        cfg_avg_log2 = 4'(n);
        cfg_ref      = 13'(rf);
        cfg_kp_shift = 4'(kp);
        cfg_ki_shift = 4'(ki);
    endtask

    // one block of 2^n samples, gap invalid cycles after each, then settle
    task automatic block(input int i, input int q, input int n, input int rf,
                         input int kp, input int ki, input int gap);
        int sum;
        sum = 0;
        setcfg(n, rf, kp, ki);
        for (int k = 0; k < (1 << n); k++) begin
            cyc(1'b1, i + (k & 1), q);
            sum += (i + (k & 1)) * (i + (k & 1)) + q * q;
            for (int g = 0; g < gap; g++) cyc(1'b0, -32, -32);
        end
        for (int k = 0; k < 4; k++) cyc(1'b0, 0, 0);
        model(sum, n, rf, kp, ki);
    endtask

    task automatic count_ones(output int c);
        c = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            c += int'(agc_bit);
        end
    endtask

    initial begin
        int c;
        int sum;
        repeat (3) @(negedge clk);
        chk("R1 reset gain", int'(gain_word), 32768);
        chk("R1 reset bit", int'(agc_bit), 0);
        enable = 1'b1;
        rst_n  = 1'b1;
        cyc(1'b0, 0, 0);
        cyc(1'b0, 0, 0);

        // table walk: R2/R3 and R6 on rows with gaps
        for (int v = 0; v < 6; v++) begin
            block(VECS[v].i, VECS[v].q, VECS[v].n, VECS[v].rf,
                  VECS[v].kp, VECS[v].ki, VECS[v].gap);
            chk((VECS[v].gap != 0) ? "R6 gapped block" : "R2/R3 block",
                int'(gain_word), m_gain);
        end

        // R7: valid held high across the block boundary
        setcfg(2, 60, 2, 2);
        for (int k = 0; k < 4; k++) cyc(1'b1, 5, 5);
        cyc(1'b1, -32, -32);
        cyc(1'b1, -32, -32);
        sum = 0;
        for (int k = 0; k < 4; k++) begin
            cyc(1'b1, 6 + (k & 1), 6);
            sum += (6 + (k & 1)) * (6 + (k & 1)) + 36;
        end
        for (int k = 0; k < 4; k++) cyc(1'b0, 0, 0);
        model(200, 2, 60, 2, 2);
        model(sum, 2, 60, 2, 2);
        chk("R7 update-cycle samples dropped", int'(gain_word), m_gain);

        // R8: enable dropped mid-block
        setcfg(2, 40, 1, 1);
        cyc(1'b1, -32, -32);
        cyc(1'b1, -32, -32);
        enable = 1'b0;
        for (int k = 0; k < 3; k++) cyc(1'b0, -32, -32);
        chk("R8 gain held while disabled", int'(gain_word), m_gain);
        enable = 1'b1;
        cyc(1'b0, 0, 0);
        cyc(1'b0, 0, 0);
        block(3, 3, 2, 40, 1, 1, 0);
        chk("R8 partial block discarded", int'(gain_word), m_gain);

        // R5: drive to upper rail, R4: integrator not wound up
        for (int b = 0; b < 8; b++) block(0, 0, 0, 8191, 15, 0, 0);
        chk("R5 upper clamp", int'(gain_word), GMAX);
        enable = 1'b0;
        cyc(1'b0, 0, 0);
        count_ones(c);
        chk("R9 density at full scale", c, 255);
        enable = 1'b1;
        cyc(1'b0, 0, 0);
        cyc(1'b0, 0, 0);
        block(-32, -32, 0, 0, 15, 0, 0);
        chk("R4 leaves rail next block", int'(gain_word), 63486);

        for (int b = 0; b < 40; b++) block(-32, -32, 0, 0, 15, 0, 0);
        chk("R5 lower clamp", int'(gain_word), 0);
        enable = 1'b0;
        cyc(1'b0, 0, 0);
        count_ones(c);
        chk("R9 density at zero", c, 0);
        enable = 1'b1;
        cyc(1'b0, 0, 0);
        cyc(1'b0, 0, 0);

        block(0, 0, 0, 8191, 15, 0, 0);
        block(0, 0, 0, 8191, 15, 0, 0);
        chk("R3 mid-scale gain", int'(gain_word), 16382);
        enable = 1'b0;
        cyc(1'b0, 0, 0);
        count_ones(c);
        chk("R9 density mid-scale", c, 63);
        cfg_invert = 1'b1;
        cyc(1'b0, 0, 0);
        count_ones(c);
        chk("R10 inverted density", c, 193);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule